// File: doc/BRIEF.md
# Translation Buffer with Page Access Rights

This block is a small, fully associative translation buffer that sits between a processor's address generator and the physical memory path. A lookup carries a virtual address, an access kind and the current privilege mode. The upper bits of the address form the virtual page number, which is compared against the tags of every valid slot. On a match, the block forms the physical address by placing the stored physical page number above the unchanged page offset. It also checks the requested access against the rights held for that page. The result arrives one clock after the request, as exactly one of hit, miss or fault.

Software or a table walker loads slots through a refill port. Each slot holds a tag, a physical page number, a two-bit rights code, a supervisor-only flag, a lock flag and a dirty flag. A flush pulse marks every unlocked slot invalid in one cycle, which suits a context switch. Locked slots survive flushes and are never picked for replacement. With translation disabled, addresses pass through untouched.

Top module: `pgx_tlb`

## Requirements
- R1: A request with translation enabled that matches a valid slot and is permitted returns, one cycle later, rs_hit=1 and rs_paddr equal to the slot's physical page number above the request's low PAGE_BITS offset bits.
- R2: A request with translation enabled that matches no valid slot returns rs_miss=1, rs_paddr=0 and rs_dirty=0.
- R3: Rights code 0 allows loads only, 1 allows loads and stores, 2 allows fetches only, and 3 allows all three. Access kind 0 is load, 1 is store, 2 is fetch, and 3 is reserved and always refused. A refused access on a matching slot returns rs_fault=1 with rs_paddr=0.
- R4: A user-mode request (lk_user=1) to a slot whose supervisor-only flag is set returns rs_fault=1, whatever its rights code.
- R5: While rs_valid is 1, exactly one of rs_hit, rs_miss and rs_fault is 1. While rs_valid is 0, all three are 0.
- R6: A permitted store sets the slot's dirty flag. On every hit, rs_dirty shows the slot's dirty flag including the effect of that same access. A refused store leaves the flag unchanged, and a refill of a slot clears it.
- R7: A refill whose page number matches a valid slot overwrites that slot. Otherwise it takes the lowest-numbered invalid slot. Otherwise it takes the first unlocked slot at or after a round-robin pointer (reset to 0), and the pointer then moves to the slot after the one taken. When every slot is valid and locked, the refill is dropped.
- R8: A flush pulse clears, in one cycle, the valid flag of every unlocked slot. Locked slots stay valid and keep their contents.
- R9: With xlat_en=0, every request returns rs_hit=1 with rs_paddr equal to lk_vaddr, rs_dirty=0 and no fault, whatever the table holds.
- R10: After reset, all slots are invalid, the result outputs are 0 and the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable; 0 passes addresses through |
| lk_req | input | 1 | Lookup request strobe |
| lk_vaddr | input | VA_W | Virtual address of the request |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_user | input | 1 | 1 when the request comes from user mode |
| rs_valid | output | 1 | Result present, one cycle after lk_req |
| rs_paddr | output | PA_W | Physical address on a hit, otherwise 0 |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No valid slot matched |
| rs_fault | output | 1 | Slot matched but the access was refused |
| rs_dirty | output | 1 | Dirty flag of the hit slot after this access |
| fill_req | input | 1 | Refill strobe |
| fill_vpn | input | VA_W-PAGE_BITS | Virtual page number to install |
| fill_ppn | input | PA_W-PAGE_BITS | Physical page number to install |
| fill_rights | input | 2 | Rights code for the new slot |
| fill_sup | input | 1 | Supervisor-only flag for the new slot |
| fill_lock | input | 1 | Lock flag for the new slot |
| flush | input | 1 | Invalidate all unlocked slots |

## Verification
The assertions check several properties on every cycle. The result flags must be exclusive. The page offset must be carried through on every hit. Bypass results must equal the request address. Misses and faults must give a zero address. A flush must leave exactly the locked slots valid. Locked slots must never lose their valid flag, and dirty flags must never fall except through a refill. Only the bench's scenarios can show the right page number for each tag and the full rights-by-kind-by-mode grid. They also cover the order in which refills pick their slots, including the round-robin walk past locked slots and the dropped refill when every slot is locked.

// File: rtl/pgx_tlb_pkg.sv
`timescale 1ns/1ps
package pgx_tlb_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      RIGHTS_RO  = 2'd0,
      RIGHTS_RW  = 2'd1,
      RIGHTS_XO  = 2'd2,
      RIGHTS_RWX = 2'd3
   } rights_e;

   // Replacement policies selectable by parameter
   localparam int unsigned VICTIM_RR     = 0;
   localparam int unsigned VICTIM_LOWEST = 1;

   function automatic logic kind_granted(rights_e r, acc_kind_e k);
      logic g;
      case (k)
         ACC_LOAD:  g = (r == RIGHTS_RO) || (r == RIGHTS_RW) || (r == RIGHTS_RWX);
         ACC_STORE: g = (r == RIGHTS_RW) || (r == RIGHTS_RWX);
         ACC_FETCH: g = (r == RIGHTS_XO) || (r == RIGHTS_RWX);
         default:   g = 1'b0;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/pgx_tlb_cam.sv
`timescale 1ns/1ps
// Tag match array: compares one key against every valid slot and returns the
// lowest matching slot index.
module pgx_tlb_cam #(
   parameter int unsigned N     = 16,
   parameter int unsigned KEY_W = 20,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]            valid_i,
   input  logic [N-1:0][KEY_W-1:0] tag_i,
   input  logic [KEY_W-1:0]        key_i,
   output logic                    any_o,
   output logic [IDX_W-1:0]        idx_o
);

   logic [N-1:0] match;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match[i] = valid_i[i] && (tag_i[i] == key_i);
   end

   assign any_o = |match;

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/pgx_tlb_perm.sv
`timescale 1ns/1ps
// Access rights check for one slot against one request.
module pgx_tlb_perm
   import pgx_tlb_pkg::*;
(
   input  logic [1:0] rights_i,
   input  logic [1:0] kind_i,
   input  logic       sup_only_i,
   input  logic       user_i,
   output logic       allow_o,
   output logic       store_o
);

   acc_kind_e kind;
   rights_e   rights;

   assign kind    = acc_kind_e'(kind_i);
   assign rights  = rights_e'(rights_i);
   assign store_o = (kind == ACC_STORE);
   assign allow_o = kind_granted(rights, kind) && !(sup_only_i && user_i);

endmodule

// File: rtl/pgx_tlb_victim.sv
`timescale 1ns/1ps
// Refill slot chooser: same-page slot, else lowest free slot, else a victim
// chosen by the configured policy among unlocked slots.
module pgx_tlb_victim
   import pgx_tlb_pkg::*;
#(
   parameter int unsigned N      = 16,
   parameter int unsigned IDX_W  = $clog2(N),
   parameter int unsigned POLICY = VICTIM_RR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     valid_i,
   input  logic [N-1:0]     lock_i,
   input  logic             same_i,
   input  logic [IDX_W-1:0] same_idx_i,
   input  logic             fill_i,
   output logic             take_o,
   output logic [IDX_W-1:0] slot_o
);

   logic             free_any;
   logic [IDX_W-1:0] free_idx;
   logic             evict_any;
   logic [IDX_W-1:0] evict_idx;

   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_i[i]) free_idx = IDX_W'(i);
      end
   end
   assign free_any = ~&valid_i;

   if (POLICY == VICTIM_RR) begin : g_rr
      logic [IDX_W-1:0] rr_q;
      logic [IDX_W-1:0] cand;

      always_comb begin
         evict_any = 1'b0;
         evict_idx = rr_q;
         cand      = rr_q;
         for (int k = N - 1; k >= 0; k--) begin
            cand = rr_q + IDX_W'(k);
            if (!lock_i[cand]) begin
               evict_any = 1'b1;
               evict_idx = cand;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rr_q <= '0;
         end else if (fill_i && !same_i && !free_any && evict_any) begin
            rr_q <= evict_idx + IDX_W'(1);
         end
      end
   end else begin : g_lowest
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign evict_any  = ~&lock_i;
      always_comb begin
         evict_idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (!lock_i[i]) evict_idx = IDX_W'(i);
         end
      end
   end

   assign take_o = fill_i && (same_i || free_any || evict_any);
   assign slot_o = same_i   ? same_idx_i :
                   free_any ? free_idx   : evict_idx;

endmodule

// File: rtl/pgx_tlb.sv
`timescale 1ns/1ps
// Fully associative translation buffer with per-page access rights.
module pgx_tlb
   import pgx_tlb_pkg::*;
#(
   parameter int unsigned ENTRIES   = 16,
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned POLICY    = VICTIM_RR
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      xlat_en,
   input  logic                      lk_req,
   input  logic [VA_W-1:0]           lk_vaddr,
   input  logic [1:0]                lk_kind,
   input  logic                      lk_user,
   output logic                      rs_valid,
   output logic [PA_W-1:0]           rs_paddr,
   output logic                      rs_hit,
   output logic                      rs_miss,
   output logic                      rs_fault,
   output logic                      rs_dirty,
   input  logic                      fill_req,
   input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
   input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
   input  logic [1:0]                fill_rights,
   input  logic                      fill_sup,
   input  logic                      fill_lock,
   input  logic                      flush
);

   localparam int unsigned VPN_W = VA_W - PAGE_BITS;
   localparam int unsigned PPN_W = PA_W - PAGE_BITS;
   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   // Elaboration-time parameter checks
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("pgx_tlb: ENTRIES must be a power of two, at least 2");
   end
   if (PAGE_BITS == 0 || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("pgx_tlb: PAGE_BITS must lie between 1 and VA_W-1");
   end
   if (PA_W < VA_W) begin : g_bad_pa
      $error("pgx_tlb: PA_W must be at least VA_W for pass-through");
   end
   if (POLICY != VICTIM_RR && POLICY != VICTIM_LOWEST) begin : g_bad_policy
      $error("pgx_tlb: unknown replacement policy");
   end

   // Slot storage
   logic [ENTRIES-1:0]            e_valid;
   logic [ENTRIES-1:0]            e_lock;
   logic [ENTRIES-1:0]            e_dirty;
   logic [ENTRIES-1:0]            e_sup;
   logic [ENTRIES-1:0][VPN_W-1:0] e_tag;
   logic [ENTRIES-1:0][PPN_W-1:0] e_ppn;
   logic [ENTRIES-1:0][1:0]       e_rights;

   // Lookup path
   logic [VPN_W-1:0]     lk_vpn;
   logic [PAGE_BITS-1:0] lk_off;
   logic                 lk_any;
   logic [IDX_W-1:0]     lk_idx;
   logic                 lk_allow;
   logic                 lk_store;
   logic                 lk_hit;
   logic                 mark_dirty;

   assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
   assign lk_off = lk_vaddr[PAGE_BITS-1:0];

   pgx_tlb_cam #(
      .N    (ENTRIES),
      .KEY_W(VPN_W),
      .IDX_W(IDX_W)
   ) u_lk_cam (
      .valid_i(e_valid),
      .tag_i  (e_tag),
      .key_i  (lk_vpn),
      .any_o  (lk_any),
      .idx_o  (lk_idx)
   );

   pgx_tlb_perm u_perm (
      .rights_i  (e_rights[lk_idx]),
      .kind_i    (lk_kind),
      .sup_only_i(e_sup[lk_idx]),
      .user_i    (lk_user),
      .allow_o   (lk_allow),
      .store_o   (lk_store)
   );

   assign lk_hit     = xlat_en && lk_any && lk_allow;
   assign mark_dirty = lk_req && lk_hit && lk_store;

   // Refill path
   logic             fill_same;
   logic [IDX_W-1:0] fill_same_idx;
   logic             fill_take;
   logic [IDX_W-1:0] fill_slot;

   pgx_tlb_cam #(
      .N    (ENTRIES),
      .KEY_W(VPN_W),
      .IDX_W(IDX_W)
   ) u_fill_cam (
      .valid_i(e_valid),
      .tag_i  (e_tag),
      .key_i  (fill_vpn),
      .any_o  (fill_same),
      .idx_o  (fill_same_idx)
   );

   pgx_tlb_victim #(
      .N     (ENTRIES),
      .IDX_W (IDX_W),
      .POLICY(POLICY)
   ) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (e_valid),
      .lock_i    (e_lock),
      .same_i    (fill_same),
      .same_idx_i(fill_same_idx),
      .fill_i    (fill_req),
      .take_o    (fill_take),
      .slot_o    (fill_slot)
   );

   // Per-slot state update
   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic load_here;
      logic dirty_here;
      assign load_here  = fill_take && (fill_slot == IDX_W'(i));
      assign dirty_here = mark_dirty && (lk_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_valid[i]  <= 1'b0;
            e_lock[i]   <= 1'b0;
            e_dirty[i]  <= 1'b0;
            e_sup[i]    <= 1'b0;
            e_tag[i]    <= '0;
            e_ppn[i]    <= '0;
            e_rights[i] <= '0;
         end else if (load_here) begin
            e_valid[i]  <= 1'b1;
            e_lock[i]   <= fill_lock;
            e_dirty[i]  <= 1'b0;
            e_sup[i]    <= fill_sup;
            e_tag[i]    <= fill_vpn;
            e_ppn[i]    <= fill_ppn;
            e_rights[i] <= fill_rights;
         end else begin
            if (flush && !e_lock[i]) e_valid[i] <= 1'b0;
            if (dirty_here)          e_dirty[i] <= 1'b1;
         end
      end
   end

   // Result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_miss  <= 1'b0;
         rs_fault <= 1'b0;
         rs_dirty <= 1'b0;
         rs_paddr <= '0;
      end else begin
         rs_valid <= lk_req;
         rs_hit   <= lk_req && (!xlat_en || lk_hit);
         rs_miss  <= lk_req && xlat_en && !lk_any;
         rs_fault <= lk_req && xlat_en && lk_any && !lk_allow;
         rs_dirty <= lk_req && lk_hit && (e_dirty[lk_idx] || lk_store);
         if (!lk_req)
            rs_paddr <= '0;
         else if (!xlat_en)
            rs_paddr <= PA_W'(lk_vaddr);
         else if (lk_hit)
            rs_paddr <= {e_ppn[lk_idx], lk_off};
         else
            rs_paddr <= '0;
      end
   end

endmodule

// File: rtl/pgx_tlb_chk.sv
`timescale 1ns/1ps
// Property checker attached to every pgx_tlb instance.
module pgx_tlb_chk #(
   parameter int unsigned ENTRIES   = 16,
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 32,
   parameter int unsigned PAGE_BITS = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               xlat_en,
   input logic [VA_W-1:0]    lk_vaddr,
   input logic               rs_valid,
   input logic [PA_W-1:0]    rs_paddr,
   input logic               rs_hit,
   input logic               rs_miss,
   input logic               rs_fault,
   input logic               rs_dirty,
   input logic               fill_req,
   input logic               flush,
   input logic [ENTRIES-1:0] e_valid,
   input logic [ENTRIES-1:0] e_lock,
   input logic [ENTRIES-1:0] e_dirty
);

   p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid |-> $onehot({rs_hit, rs_miss, rs_fault}));

   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |-> !(rs_hit || rs_miss || rs_fault));

   p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_hit) |->
         rs_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0]));

   p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !$past(xlat_en)) |->
         (rs_hit && !rs_dirty && rs_paddr == PA_W'($past(lk_vaddr))));

   p_zero_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_hit) |-> (rs_paddr == '0 && !rs_dirty));

   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush) && !$past(fill_req)) |->
         (e_valid == ($past(e_valid) & $past(e_lock))));

   p_locked_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(e_valid) & $past(e_lock) & ~e_valid) == '0));

   p_dirty_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fill_req) |-> (($past(e_dirty) & ~e_dirty) == '0));

endmodule

bind pgx_tlb pgx_tlb_chk #(
   .ENTRIES  (ENTRIES),
   .VA_W     (VA_W),
   .PA_W     (PA_W),
   .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .xlat_en (xlat_en),
   .lk_vaddr(lk_vaddr),
   .rs_valid(rs_valid),
   .rs_paddr(rs_paddr),
   .rs_hit  (rs_hit),
   .rs_miss (rs_miss),
   .rs_fault(rs_fault),
   .rs_dirty(rs_dirty),
   .fill_req(fill_req),
   .flush   (flush),
   .e_valid (e_valid),
   .e_lock  (e_lock),
   .e_dirty (e_dirty)
);

// File: tb/sim_pgx_tlb.sv
`timescale 1ns/1ps
module sim_pgx_tlb;

   localparam int N  = 16;
   localparam int VW = 32;
   localparam int PW = 32;
   localparam int PB = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          xlat_en;
   logic          lk_req;
   logic [VW-1:0] lk_vaddr;
   logic [1:0]    lk_kind;
   logic          lk_user;
   logic          rs_valid;
   logic [PW-1:0] rs_paddr;
   logic          rs_hit, rs_miss, rs_fault, rs_dirty;
   logic          fill_req;
   logic [19:0]   fill_vpn, fill_ppn;
   logic [1:0]    fill_rights;
   logic          fill_sup, fill_lock, flush;

   always #2.5 clk = ~clk;

   pgx_tlb u0 (
      .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
      .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_user(lk_user),
      .rs_valid(rs_valid), .rs_paddr(rs_paddr), .rs_hit(rs_hit),
      .rs_miss(rs_miss), .rs_fault(rs_fault), .rs_dirty(rs_dirty),
      .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_rights(fill_rights), .fill_sup(fill_sup), .fill_lock(fill_lock),
      .flush(flush)
   );

   typedef struct packed {
      logic [31:0] pa;
      logic        h;
      logic        m;
      logic        f;
      logic        d;
   } res_t;

   int    errors = 0;
   int    checks = 0;
   bit    finished = 0;
   res_t  exp_q[$];
   string tag_q[$];

   // Reference model of the table
   bit          m_v[N];
   bit          m_l[N];
   bit          m_d[N];
   bit          m_s[N];
   logic [19:0] m_tag[N];
   logic [19:0] m_ppn[N];
   logic [1:0]  m_r[N];
   int          m_rr;

   function automatic bit allowed(logic [1:0] r, logic [1:0] k, bit s, bit u);
      bit g;
      case (k)
         2'd0:    g = (r != 2'd2);
         2'd1:    g = (r == 2'd1) || (r == 2'd3);
         2'd2:    g = (r == 2'd2) || (r == 2'd3);
         default: g = 0;
      endcase
      return g && !(s && u);
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lk_req = 0; fill_req = 0; flush = 0;
      end
   endtask

   task automatic set_xlat(input logic en);
      @(negedge clk);
      lk_req = 0; fill_req = 0; flush = 0;
      xlat_en = en;
   endtask

   // Driver: issues a lookup and pushes the expected result
   task automatic lookup(input logic [31:0] va, input logic [1:0] kind,
                         input logic user, input string tag);
      res_t  e;
      int    idx;
      string t;
      idx = -1;
      t   = tag;
      @(negedge clk);
      fill_req = 0; flush = 0;
      lk_req = 1; lk_vaddr = va; lk_kind = kind; lk_user = user;
      if (!xlat_en) begin
         e = '{pa: va, h: 1, m: 0, f: 0, d: 0};
         if (t == "") t = "R9";
      end else begin
         for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == va[31:12]) idx = i;
         if (idx < 0) begin
            e = '{pa: 0, h: 0, m: 1, f: 0, d: 0};
            if (t == "") t = "R2";
         end else if (!allowed(m_r[idx], kind, m_s[idx], user)) begin
            e = '{pa: 0, h: 0, m: 0, f: 1, d: 0};
            if (t == "") t = (m_s[idx] && user) ? "R4" : "R3";
         end else begin
            if (kind == 2'd1) m_d[idx] = 1;
            e = '{pa: {m_ppn[idx], va[11:0]}, h: 1, m: 0, f: 0, d: m_d[idx]};
            if (t == "") t = (kind == 2'd1 || m_d[idx]) ? "R6" : "R1";
         end
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic [1:0] r, input bit s, input bit l);
      int slot;
      bit via_rr;
      slot   = -1;
      via_rr = 0;
      @(negedge clk);
      lk_req = 0; flush = 0;
      fill_req = 1; fill_vpn = vpn; fill_ppn = ppn;
      fill_rights = r; fill_sup = s; fill_lock = l;
      for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) slot = i;
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
         for (int k = N - 1; k >= 0; k--) begin
            if (!m_l[(m_rr + k) % N]) begin
               slot   = (m_rr + k) % N;
               via_rr = 1;
            end
         end
      end
      if (slot >= 0) begin
         m_v[slot] = 1; m_l[slot] = l; m_d[slot] = 0; m_s[slot] = s;
         m_tag[slot] = vpn; m_ppn[slot] = ppn; m_r[slot] = r;
         if (via_rr) m_rr = (slot + 1) % N;
      end
   endtask

   task automatic do_flush();
      @(negedge clk);
      lk_req = 0; fill_req = 0;
      flush = 1;
      for (int i = 0; i < N; i++) if (!m_l[i]) m_v[i] = 0;
   endtask

   // Monitor: pops expectations as results appear
   res_t  act;
   res_t  exp_r;
   string exp_t;
   always @(negedge clk) begin
      if (rst_n && rs_valid) begin
         act = '{pa: rs_paddr, h: rs_hit, m: rs_miss, f: rs_fault, d: rs_dirty};
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R5 result without request act=%h exp=none", act);
         end else begin
            exp_r = exp_q.pop_front();
            exp_t = tag_q.pop_front();
            if (act !== exp_r) begin
               errors++;
               $display("FAIL %s paddr/hit/miss/fault/dirty act=%h exp=%h", exp_t, act, exp_r);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=done");
      finish_run();
   end

   initial begin
      rst_n = 0; xlat_en = 1; lk_req = 0; lk_vaddr = 0; lk_kind = 0; lk_user = 0;
      fill_req = 0; fill_vpn = 0; fill_ppn = 0; fill_rights = 0;
      fill_sup = 0; fill_lock = 0; flush = 0;
      m_rr = 0;
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_l[i] = 0; m_d[i] = 0; m_s[i] = 0;
         m_tag[i] = 0; m_ppn[i] = 0; m_r[i] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: outputs quiet after reset
      checks++;
      if ({rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty} !== 5'b0 || rs_paddr !== '0) begin
         errors++;
         $display("FAIL R10 reset outputs act=%b/%h exp=0/0",
                  {rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty}, rs_paddr);
      end
      lookup(32'h0010_0123, 2'd0, 0, "R10");

      // Load every slot; slots 0 and 1 locked
      for (int i = 0; i < N; i++)
         fill(20'h00100 + 20'(i), 20'h08000 + 20'(i * 3), 2'(i % 4), (i % 5) == 4, i < 2);

      // R1, R3, R4, R6: full grid of kinds and modes
      for (int i = 0; i < N; i++)
         for (int k = 0; k < 4; k++)
            for (int u = 0; u < 2; u++)
               lookup({20'h00100 + 20'(i), 12'h0A0 + 12'(i)}, 2'(k), u[0], "");

      // R6: dirty flags seen on later loads
      for (int i = 0; i < N; i++)
         lookup({20'h00100 + 20'(i), 12'hFFF}, 2'd0, 0, "R6");

      // R2: unknown pages
      lookup(32'hABCD_E000, 2'd0, 0, "R2");
      lookup(32'h0000_0FFF, 2'd2, 1, "R2");

      // R9: pass-through
      set_xlat(0);
      lookup(32'h0010_3456, 2'd1, 1, "R9");
      lookup(32'hDEAD_BEEF, 2'd3, 1, "R9");
      lookup(32'h0000_0000, 2'd2, 0, "R9");
      set_xlat(1);

      // R7: replacement walks past locked slots 0 and 1
      fill(20'h00200, 20'h0AAA0, 2'd3, 0, 0);
      fill(20'h00201, 20'h0AAA1, 2'd3, 0, 0);
      fill(20'h00202, 20'h0AAA2, 2'd3, 0, 0);
      lookup(32'h0020_0010, 2'd0, 0, "R7");
      lookup(32'h0020_2010, 2'd0, 0, "R7");
      lookup(32'h0010_2010, 2'd0, 0, "R7");
      lookup(32'h0010_4010, 2'd0, 0, "R7");
      lookup(32'h0010_0010, 2'd0, 0, "R7");
      lookup(32'h0010_5010, 2'd0, 0, "R7");

      // R7/R6: refill of an existing page overwrites it and clears dirty
      lookup(32'h0010_5020, 2'd1, 0, "R6");
      fill(20'h00105, 20'h00ABC, 2'd1, 0, 0);
      lookup(32'h0010_5020, 2'd0, 0, "R7");
      lookup(32'h0010_5024, 2'd1, 0, "R6");
      lookup(32'h0010_5028, 2'd0, 0, "R6");

      // R8: flush keeps only locked slots
      do_flush();
      for (int i = 0; i < N; i++)
         lookup({20'h00100 + 20'(i), 12'h004}, 2'd0, 0, "R8");
      lookup(32'h0020_0004, 2'd0, 0, "R8");
      lookup(32'h0020_1004, 2'd0, 0, "R8");

      // R7: fill remaining slots locked, then a further refill is dropped
      for (int i = 0; i < N - 2; i++)
         fill(20'h00300 + 20'(i), 20'h0C000 + 20'(i), 2'd3, 0, 1);
      fill(20'h003FF, 20'h0FFFF, 2'd3, 0, 0);
      lookup(32'h003F_F000, 2'd0, 0, "R7");
      lookup(32'h0030_0100, 2'd0, 0, "R7");
      lookup(32'h0030_D100, 2'd0, 0, "R7");
      do_flush();
      lookup(32'h0030_7100, 2'd0, 0, "R8");
      lookup(32'h0010_0100, 2'd0, 0, "R8");

      idle(4);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R5 missing results act=%0d exp=0", exp_q.size());
      end
      finish_run();
   end

endmodule